// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

The block gathers fifteen interrupt sources, numbered 1 to 15, and presents one 4-bit request level to a processor. A source becomes active when it is latched as pending by a rising edge on its input, or when software sets its force bit. An active source is only offered to the processor when its mask bit is set. Each source also has a priority-group bit. Any unmasked source in the high group outranks every source in the low group. Inside a group, the higher source number wins.

Software reaches the controller over a simple single-cycle 32-bit register bus. There are five registers: priority group at 0x00, pending at 0x04 (read only), force at 0x08, clear at 0x0C (write only) and mask at 0x40. Sources occupy bits 15:1, and bit 0 is unused. The processor answers a request with a one-cycle acknowledge strobe that carries the level being serviced. The controller then clears that source's force bit if one is set, and otherwise its pending bit. Once every forced source has been serviced, the force register therefore reads zero. The interrupt inputs are assumed to be synchronous to the clock.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0 and `irq_lvl` is 0.
- R2: Writes to the group (0x00), force (0x08) and mask (0x40) registers read back bits 15:1 of the written word. Bit 0 and bits 31:16 read 0.
- R3: A 0-to-1 transition on `irq_in[n]` (n = 1..15) sets pending bit n at the next clock edge. An input held high does not set the bit again after it has been cleared.
- R4: Writing the clear register (0x0C) removes the pending bits written as 1 and leaves the others unchanged. Writing all ones empties the pending register.
- R5: One clock after the register state changes, `irq_lvl` equals the highest-numbered active source (pending OR force, AND mask) whose group bit is 1. If no such source exists, it equals the highest-numbered active source. If nothing is active, it is 0.
- R6: With the mask register at 0, `irq_lvl` stays 0 even when force or pending bits are set.
- R7: An acknowledge of an active level N clears force bit N when it is set, and leaves pending bit N unchanged. Otherwise it clears pending bit N.
- R8: An acknowledge whose level is 0, or names a source that is not active (including a masked one), changes no register and no output.
- R9: Writes to the pending register address (0x04) have no effect.
- R10: With all fifteen sources forced and unmasked and every presented level acknowledged in turn, the sequence is 15 down to 1 when all group bits are 0. With group bits 0xAAAA it is 15, 13, ..., 1 followed by 14, 12, ..., 2. Afterwards the force register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq_in | input | 16 | Interrupt inputs, bit n for source n, bit 0 unused |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_lvl | input | 4 | Level being acknowledged |
| irq_lvl | output | 4 | Registered level of the highest-priority request, 0 when idle |

## Verification
The hardest case to reach is a source that is pending and forced at the same moment, because the acknowledge must remove only the force bit. The bench gets there by pulsing an input and then writing the force register for the same source, and reads both registers back between two acknowledges. The full acknowledge sequences use the level that `irq_lvl` shows, fed back into `ack_lvl`. This checks both the group order and the one-cycle update of the output at every step.

// File: rtl/irq_pkg.sv
// Shared sizes and register offsets for the interrupt controller.
// Assumes sources 1..NSRC occupy a vector whose bit 0 is unused.
package irq_pkg;
    localparam int NSRC   = 15;
    localparam int SRC_W  = NSRC + 1;
    localparam int LVL_W  = $clog2(SRC_W);
    localparam int OFF_GROUP = 8'h00;
    localparam int OFF_PEND  = 8'h04;
    localparam int OFF_FORCE = 8'h08;
    localparam int OFF_CLEAR = 8'h0C;
    localparam int OFF_MASK  = 8'h40;
endpackage

// File: rtl/irq_edge_det.sv
// Rising-edge detector for the interrupt inputs.
// Assumes the inputs are already synchronous to clk.
module irq_edge_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Remember last cycle's input level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/irq_src_bank.sv
// Per-source state: group, mask, force and pending bits.
// Bit 0 of every vector is tied to 0. Group, mask and force are loaded
// from write data. Pending is set by edges, cleared by the clear register
// and by acknowledges, and cannot be written directly.
module irq_src_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         grp_wr,
    input  logic         msk_wr,
    input  logic         frc_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] ack_clr_frc,
    input  logic [W-1:0] ack_clr_pnd,
    output logic [W-1:0] group_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] force_q,
    output logic [W-1:0] pend_q
);
    logic unused_bit0;
    assign unused_bit0 = ^{wdata[0], rise[0], ack_clr_frc[0], ack_clr_pnd[0]};

    assign group_q[0] = 1'b0;
    assign mask_q[0]  = 1'b0;
    assign force_q[0] = 1'b0;
    assign pend_q[0]  = 1'b0;

    for (genvar i = 1; i < W; i++) begin : g_src
        // Update the four state bits of source i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                group_q[i] <= 1'b0;
                mask_q[i]  <= 1'b0;
                force_q[i] <= 1'b0;
                pend_q[i]  <= 1'b0;
            end else begin
                if (grp_wr) group_q[i] <= wdata[i];
                if (msk_wr) mask_q[i]  <= wdata[i];
                if (frc_wr) force_q[i] <= wdata[i];
                else        force_q[i] <= force_q[i] & ~ack_clr_frc[i];
                pend_q[i] <= (pend_q[i] & ~(clr_wr & wdata[i]) & ~ack_clr_pnd[i])
                             | rise[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Two-group priority encoder with a registered level output.
// The high group (group bit 1) is searched first. Within a group the
// highest index wins. The output is 0 when no bit is active.
module irq_prio_enc #(
    parameter int W     = 16,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     active,
    input  logic [W-1:0]     group,
    output logic [LVL_W-1:0] lvl
);
    function automatic logic [LVL_W-1:0] top_index(input logic [W-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i < W; i++)
            if (v[i]) r = LVL_W'(i);
        return r;
    endfunction

    logic [W-1:0]     hi_set;
    logic [LVL_W-1:0] hi_idx, any_idx, nxt_lvl;

    // Choose the winning level from the high group first, then from all.
    always_comb begin
        hi_set  = active & group;
        hi_idx  = top_index(hi_set);
        any_idx = top_index(active);
        nxt_lvl = (|hi_set) ? hi_idx : any_idx;
    end

    // Register the presented level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl <= '0;
        else        lvl <= nxt_lvl;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the two-group interrupt controller: bus decode, acknowledge
// handling and read mux. Assumes single-cycle 32-bit accesses and
// interrupt inputs that are synchronous to clk.
module irq_prio_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [irq_pkg::SRC_W-1:0]  irq_in,
    input  logic                       ack_valid,
    input  logic [irq_pkg::LVL_W-1:0]  ack_lvl,
    output logic [irq_pkg::LVL_W-1:0]  irq_lvl
);
    import irq_pkg::*;

    logic             wr_en, rd_en;
    logic             grp_wr, msk_wr, frc_wr, clr_wr;
    logic [SRC_W-1:0] rise, group_q, mask_q, force_q, pend_q, act_vec;
    logic [SRC_W-1:0] ack_sel, ack_clr_frc, ack_clr_pnd;
    logic             ack_hit;
    logic             unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:SRC_W];

    // Decode register writes.
    always_comb begin
        wr_en  = bus_sel & bus_wr;
        rd_en  = bus_sel & ~bus_wr;
        grp_wr = wr_en & (bus_addr == ADDR_W'(OFF_GROUP));
        msk_wr = wr_en & (bus_addr == ADDR_W'(OFF_MASK));
        frc_wr = wr_en & (bus_addr == ADDR_W'(OFF_FORCE));
        clr_wr = wr_en & (bus_addr == ADDR_W'(OFF_CLEAR));
    end

    irq_edge_det #(.W(SRC_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(irq_in), .rise(rise)
    );

    // Qualify an acknowledge and steer it to force or pending.
    always_comb begin
        act_vec     = (pend_q | force_q) & mask_q;
        ack_hit     = ack_valid & (ack_lvl != '0) & act_vec[ack_lvl];
        ack_sel     = ack_hit ? (SRC_W'(1) << ack_lvl) : '0;
        ack_clr_frc = ack_sel & force_q;
        ack_clr_pnd = ack_sel & ~force_q;
    end

    irq_src_bank #(.W(SRC_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wdata(bus_wdata[SRC_W-1:0]),
        .grp_wr(grp_wr), .msk_wr(msk_wr), .frc_wr(frc_wr), .clr_wr(clr_wr),
        .rise(rise), .ack_clr_frc(ack_clr_frc), .ack_clr_pnd(ack_clr_pnd),
        .group_q(group_q), .mask_q(mask_q), .force_q(force_q), .pend_q(pend_q)
    );

    irq_prio_enc #(.W(SRC_W), .LVL_W(LVL_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .active(act_vec), .group(group_q), .lvl(irq_lvl)
    );

    // Read mux; clear and unmapped addresses read as zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                ADDR_W'(OFF_GROUP): bus_rdata = DATA_W'(group_q);
                ADDR_W'(OFF_PEND):  bus_rdata = DATA_W'(pend_q);
                ADDR_W'(OFF_FORCE): bus_rdata = DATA_W'(force_q);
                ADDR_W'(OFF_MASK):  bus_rdata = DATA_W'(mask_q);
                default:            bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_prio_checker.sv
// Timing properties of the interrupt controller, bound to its top.
module irq_prio_checker #(
    parameter int W     = 16,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     act_vec,
    input logic [W-1:0]     mask_q,
    input logic [W-1:0]     force_q,
    input logic             frc_wr,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ack_lvl,
    input logic [LVL_W-1:0] irq_lvl
);
    logic [W-1:0] act_d;

    // Keep last cycle's active set for the level check.
    always_ff @(posedge clk) begin
        if (!rst_n) act_d <= '0;
        else        act_d <= act_vec;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vec == '0) |=> (irq_lvl == '0));  // R5
    AST_LVL_WAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != '0) |-> act_d[irq_lvl]);  // R5
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> (irq_lvl == '0));  // R6
    AST_FORCE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_lvl != '0 && act_vec[ack_lvl] && force_q[ack_lvl] && !frc_wr)
        |=> !force_q[$past(ack_lvl)]);  // R7
    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !act_vec[ack_lvl] && !frc_wr) |=> $stable(force_q));  // R8
endmodule

bind irq_prio_ctrl irq_prio_checker #(.W(irq_pkg::SRC_W), .LVL_W(irq_pkg::LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .act_vec(act_vec), .mask_q(mask_q),
    .force_q(force_q), .frc_wr(frc_wr), .ack_valid(ack_valid),
    .ack_lvl(ack_lvl), .irq_lvl(irq_lvl)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [15:0] irq_in = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_lvl = '0, irq_lvl;
    int checks = 0, errors = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .ack_valid(ack_valid), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl)
    );

    // mask[63:48] group[47:32] force[31:16] expected level[15:0]
    localparam logic [63:0] VEC [9] = '{
        {16'hFFFE, 16'h0000, 16'hFFFE, 16'd15},
        {16'hFFFE, 16'h0000, 16'h0022, 16'd5},
        {16'hFFFE, 16'h0002, 16'h8002, 16'd1},
        {16'hFFFE, 16'hAAAA, 16'h4444, 16'd14},
        {16'h00FE, 16'h0000, 16'hFF00, 16'd0},
        {16'h0000, 16'h0000, 16'hFFFE, 16'd0},
        {16'hFFFE, 16'h0C00, 16'h0FFE, 16'd11},
        {16'h0400, 16'h0800, 16'h0FFE, 16'd10},
        {16'hFFFE, 16'h0000, 16'h0001, 16'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ack(input logic [3:0] l);
        ack_valid = 1'b1; ack_lvl = l;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic pulse(input int n);
        irq_in[n] = 1'b1;
        @(negedge clk);
        irq_in[n] = 1'b0;
        @(negedge clk);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq_lvl == 0, "R1 irq_lvl", irq_lvl, 0);
        rdreg(8'h00, rd); check(rd == 0, "R1 group", rd, 0);
        rdreg(8'h04, rd); check(rd == 0, "R1 pending", rd, 0);
        rdreg(8'h08, rd); check(rd == 0, "R1 force", rd, 0);
        rdreg(8'h40, rd); check(rd == 0, "R1 mask", rd, 0);

        // R2 read back
        wr(8'h40, 32'hFFFF_FFFF); rdreg(8'h40, rd); check(rd == 32'hFFFE, "R2 mask", rd, 32'hFFFE);
        wr(8'h00, 32'h1234_5679); rdreg(8'h00, rd); check(rd == 32'h5678, "R2 group", rd, 32'h5678);
        wr(8'h40, 32'h0);
        wr(8'h08, 32'hFFFF_0003); rdreg(8'h08, rd); check(rd == 32'h0002, "R2 force", rd, 32'h0002);

        // R5 R6 vector table
        foreach (VEC[k]) begin
            wr(8'h00, {16'h0, VEC[k][47:32]});
            wr(8'h40, {16'h0, VEC[k][63:48]});
            wr(8'h08, {16'h0, VEC[k][31:16]});
            @(negedge clk);
            check(irq_lvl == VEC[k][3:0], "R5/R6 vector", irq_lvl, VEC[k][3:0]);
        end

        // R10 single group order
        wr(8'h08, 0); wr(8'h00, 0); wr(8'h40, 32'hFFFE); wr(8'h08, 32'hFFFE);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            check(irq_lvl == 15 - i, "R10 flat order", irq_lvl, 15 - i);
            ack(irq_lvl);
        end
        @(negedge clk);
        rdreg(8'h08, rd); check(rd == 0, "R10 force empty", rd, 0);
        check(irq_lvl == 0, "R10 idle", irq_lvl, 0);

        // R10 two group order
        wr(8'h00, 32'hAAAA); wr(8'h08, 32'hFFFE);
        for (int i = 0; i < 15; i++) begin
            int e;
            e = (i < 8) ? 15 - 2 * i : 14 - 2 * (i - 8);
            @(negedge clk);
            check(irq_lvl == e, "R10 group order", irq_lvl, e);
            ack(irq_lvl);
        end
        @(negedge clk);
        rdreg(8'h08, rd); check(rd == 0, "R10 force empty 2", rd, 0);

        // R3 edge sets pending, held level does not re-set
        wr(8'h00, 0);
        irq_in[7] = 1'b1;
        @(negedge clk);
        rdreg(8'h04, rd); check(rd == 32'h80, "R3 edge", rd, 32'h80);
        @(negedge clk);
        check(irq_lvl == 7, "R3 level", irq_lvl, 7);
        wr(8'h0C, 32'h80);
        repeat (2) @(negedge clk);
        rdreg(8'h04, rd); check(rd == 0, "R3 held high", rd, 0);
        irq_in[7] = 1'b0;

        // R7 force and pending on the same source
        pulse(5);
        wr(8'h08, 32'h20);
        check(irq_lvl == 5, "R7 level", irq_lvl, 5);
        ack(5);
        rdreg(8'h08, rd); check(rd == 0, "R7 force cleared", rd, 0);
        rdreg(8'h04, rd); check(rd == 32'h20, "R7 pending kept", rd, 32'h20);
        ack(5);
        rdreg(8'h04, rd); check(rd == 0, "R7 pending cleared", rd, 0);

        // R8 ignored acknowledges
        pulse(5);
        ack(9);
        rdreg(8'h04, rd); check(rd == 32'h20, "R8 inactive level", rd, 32'h20);
        ack(0);
        rdreg(8'h04, rd); check(rd == 32'h20, "R8 level zero", rd, 32'h20);
        check(irq_lvl == 5, "R8 output", irq_lvl, 5);
        wr(8'h40, 0);
        ack(5);
        rdreg(8'h04, rd); check(rd == 32'h20, "R8 masked", rd, 32'h20);
        check(irq_lvl == 0, "R6 masked pending", irq_lvl, 0);

        // R9 pending not writable
        wr(8'h04, 32'hFFFE);
        rdreg(8'h04, rd); check(rd == 32'h20, "R9 pending write", rd, 32'h20);

        // R4 clear register
        pulse(3);
        rdreg(8'h04, rd); check(rd == 32'h28, "R4 two pending", rd, 32'h28);
        wr(8'h0C, 32'h08);
        rdreg(8'h04, rd); check(rd == 32'h20, "R4 partial clear", rd, 32'h20);
        wr(8'h0C, 32'hFFFF_FFFF);
        rdreg(8'h04, rd); check(rd == 0, "R4 clear all", rd, 0);

        report();
    end
endmodule